// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block moves up to eight bits at a time between a processor-visible data register and a serial EEPROM over a three-wire link: a serial clock output and one bidirectional data line. Chip select is not part of the block. Software drives it from a general-purpose output and frames each transaction around one or more commands issued here.

Software first loads the data register. It then writes the command inputs: a direction flag, a release flag and a bit count. That write starts a burst of serial clocks. A write burst shifts bits out of the top of the data register. A read burst leaves the data line undriven and shifts sampled bits in at the bottom of the register. A busy flag covers the burst, and a one-cycle interrupt pulse marks its end. A command with a bit count of zero issues no clocks. It only sets whether the engine drives the data line, which is how software takes the line back after a read.

The serial clock runs at the system clock divided by `2*HALF_DIV`. It idles low. Outgoing data changes after a falling serial clock edge, and incoming data is sampled at a rising edge.

Top module: `ser3w_engine`

## Requirements
- R1: A write of the command inputs (`cmd_wr_i`) while idle, with an effective count n > 0, raises `busy_o` on the following cycle. `busy_o` stays high for exactly 2*HALF_DIV*n system cycles.
- R2: A command with effective count n produces exactly n serial clock pulses on `sclk_o`. Each pulse is HALF_DIV cycles low followed by HALF_DIV cycles high, and `sclk_o` is low whenever `busy_o` is low. A count above 8 is treated as 8.
- R3: A write command (`cmd_rd_i`=0) drives the data line for the whole burst and sends the n bits MSB first, starting from bit 7 of the data register. The line changes only while `sclk_o` is low. At the end, the data register holds its old value shifted left by n, with zeros filled in.
- R4: A read command (`cmd_rd_i`=1, n > 0) keeps the output driver off for the whole burst and samples the line at each rising serial clock edge. The register is cleared at the start of the burst, so the n bits land right-justified in bits n-1..0 (first bit received in bit n-1) and the upper bits read as 0.
- R5: A command with count 0 issues no clocks and never raises `busy_o`. It sets the output enable to the inverse of `cmd_hiz_i`, whatever the value of `cmd_rd_i`, and pulses `irq_o` on the cycle after the write. The data register is left unchanged.
- R6: After a write burst, the output enable is the inverse of `cmd_hiz_i`. After a read burst, the output driver stays off.
- R7: `irq_o` is a single-cycle pulse. For a burst, it is high in the first cycle in which `busy_o` is low again.
- R8: Command writes and data-register writes made while `busy_o` is high are ignored. The burst in progress completes unchanged.
- R9: After reset, `busy_o`, `irq_o`, `sclk_o` and `sdio_oe_o` are 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_wr_i | input | 1 | Load data register (ignored while busy) |
| data_wdata_i | input | DATA_W | Value to load into the data register |
| cmd_wr_i | input | 1 | Start a command (ignored while busy) |
| cmd_rd_i | input | 1 | 1 = read burst, 0 = write burst |
| cmd_hiz_i | input | 1 | Release the data line after a write or zero-count command |
| cmd_cnt_i | input | CNT_W | Number of serial clocks, 0..8 (larger values clamp to 8) |
| data_o | output | DATA_W | Data register contents |
| busy_o | output | 1 | High while a burst is in progress |
| irq_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock, idle low |
| sdio_oe_o | output | 1 | Data line output enable |
| sdio_io | inout | 1 | Bidirectional serial data line |

## Verification
The in-module assertions check the following on every cycle: the serial clock is low when idle, the driver is off during reads and on during writes, outgoing data holds steady while the clock is high, the captured command is frozen while busy, the count is clamped, and the interrupt is a single pulse coinciding with the fall of busy. Other properties can only be shown by the bench's scenarios, which use an EEPROM line model and a scoreboard of expected outcomes. These are the exact pulse and busy-cycle counts, the MSB-first bit order on the line, the right-justified read result, the post-burst drive state for each flag combination, the zero-count timing, and that writes made mid-burst change nothing.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} sclk_ph_e;

  function automatic int unsigned clamp_cnt(input int unsigned cnt, input int unsigned max_bits);
    return (cnt > max_bits) ? max_bits : cnt;
  endfunction
endpackage

// File: rtl/ser3w_tick.sv
module ser3w_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_tick_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HALF_DIV - 1));
endmodule

// File: rtl/ser3w_shreg.sv
module ser3w_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              clr_i,
  input  logic              shin_i,
  input  logic              shout_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (load_i)   q_q <= load_val_i;
    else if (clr_i)    q_q <= '0;
    else if (shin_i)   q_q <= {q_q[DATA_W-2:0], sdi_i};
    else if (shout_i)  q_q <= {q_q[DATA_W-2:0], 1'b0};
  end

  assign q_o = q_q;

  p_clr_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !load_i |=> q_q == '0);
endmodule

// File: rtl/ser3w_ctrl.sv
module ser3w_ctrl
  import ser3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             hiz_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             oe_o,
  output logic             irq_o,
  output logic             rd_mode_o,
  output logic             clr_o,
  output logic             shin_o,
  output logic             shout_o
);
  logic [CNT_W-1:0] eff_cnt;
  logic [CNT_W-1:0] bits_q;
  logic             busy_q, oe_q, irq_q, rd_q, hiz_q;
  sclk_ph_e         ph_q;

  assign eff_cnt = CNT_W'(clamp_cnt(int'(cnt_i), DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= PH_LOW;
      bits_q <= '0;
      oe_q   <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= 1'b0;
      hiz_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start_i) begin
        rd_q  <= rd_i;
        hiz_q <= hiz_i;
        if (eff_cnt == '0) begin
          oe_q  <= !hiz_i;
          irq_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          ph_q   <= PH_LOW;
          bits_q <= eff_cnt;
          oe_q   <= !rd_i;
        end
      end else if (busy_q && tick_i) begin
        if (ph_q == PH_LOW) begin
          ph_q <= PH_HIGH;
        end else begin
          ph_q   <= PH_LOW;
          bits_q <= bits_q - 1'b1;
          if (bits_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            oe_q   <= rd_q ? 1'b0 : !hiz_q;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = busy_q && (ph_q == PH_HIGH);
  assign oe_o      = oe_q;
  assign irq_o     = irq_q;
  assign rd_mode_o = rd_q;
  assign clr_o     = start_i && rd_i && (eff_cnt != '0);
  assign shin_o    = busy_q && tick_i && (ph_q == PH_LOW) && rd_q;
  assign shout_o   = busy_q && tick_i && (ph_q == PH_HIGH) && !rd_q;

  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  p_bits_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q <= CNT_W'(DATA_W));
  p_read_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_q |-> !oe_o);
  p_write_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rd_q |-> oe_o);
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !start_i |=> !irq_o);
  p_busy_end_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_q) && $stable(hiz_q));
endmodule

// File: rtl/ser3w_engine.sv
module ser3w_engine #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = $clog2(DATA_W + 1),
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              cmd_wr_i,
  input  logic              cmd_rd_i,
  input  logic              cmd_hiz_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              sdio_oe_o,
  inout  wire               sdio_io
);
  logic busy, tick, start, load, clr, shin, shout, oe, rd_mode, sdo, sdi;
  logic [DATA_W-1:0] data_q;

  assign start = cmd_wr_i && !busy;
  assign load  = data_wr_i && !busy;

  ser3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .tick_o(tick)
  );

  ser3w_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rd_i     (cmd_rd_i),
    .hiz_i    (cmd_hiz_i),
    .cnt_i    (cmd_cnt_i),
    .tick_i   (tick),
    .busy_o   (busy),
    .sclk_o   (sclk_o),
    .oe_o     (oe),
    .irq_o    (irq_o),
    .rd_mode_o(rd_mode),
    .clr_o    (clr),
    .shin_o   (shin),
    .shout_o  (shout)
  );

  ser3w_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(data_wdata_i),
    .clr_i     (clr),
    .shin_i    (shin),
    .shout_i   (shout),
    .sdi_i     (sdi),
    .q_o       (data_q)
  );

  // pad model: drive when enabled, otherwise listen
  assign sdo       = data_q[DATA_W-1];
  assign sdio_io   = oe ? sdo : 1'bz;
  assign sdi       = sdio_io;
  assign sdio_oe_o = oe;
  assign busy_o    = busy;
  assign data_o    = data_q;

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !rd_mode && sclk_o |-> $stable(sdo));
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && data_wr_i && !shin && !shout |=> $stable(data_q));
endmodule

// File: tb/tb_ser3w_engine.sv
module tb_ser3w_engine;
  localparam int HALF = 2;

  typedef struct {
    logic [7:0] data;
    logic [7:0] cap;
    logic       oe;
    logic       rd;
    int         rises;
    int         busy;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_wr_i = 1'b0;
  logic [7:0] data_wdata_i = '0;
  logic       cmd_wr_i = 1'b0;
  logic       cmd_rd_i = 1'b0;
  logic       cmd_hiz_i = 1'b0;
  logic [3:0] cmd_cnt_i = '0;
  logic [7:0] data_o;
  logic       busy_o, irq_o, sclk_o, sdio_oe_o;
  wire        sdio_io;

  logic       ee_en = 1'b0;
  logic [7:0] ee_sr = '0;
  assign sdio_io = ee_en ? ee_sr[7] : 1'bz;
  always @(negedge sclk_o) ee_sr = {ee_sr[6:0], 1'b0};

  int vec = 0, bad = 0;
  exp_t sb_q[$];
  logic [7:0] sb_data = '0;
  bit done = 1'b0;

  ser3w_engine #(.DATA_W(8), .HALF_DIV(HALF)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: counts clocks, busy cycles, captures line, compares on irq
  int rises = 0, bcyc = 0;
  logic [7:0] cap = '0;
  logic sclk_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bcyc += int'(busy_o);
      if (sclk_o && !sclk_prev) begin
        rises++;
        if (sdio_oe_o) cap = {cap[6:0], sdio_io};
      end
      sclk_prev = sclk_o;
      if (irq_o) begin
        if (sb_q.size() == 0) begin
          chk("R7", "unexpected irq", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R2", "sclk pulses", rises, e.rises);
          chk("R1", "busy cycles", bcyc, e.busy);
          chk("R7", "busy low at irq", int'(busy_o), 0);
          chk(e.rd ? "R4" : "R3", "data reg", int'(data_o), int'(e.data));
          if (!e.rd) chk("R3", "bits on line", int'(cap), int'(e.cap));
          chk(e.rises == 0 ? "R5" : "R6", "drive state", int'(sdio_oe_o), int'(e.oe));
        end
        rises = 0; bcyc = 0; cap = '0;
      end
    end
  end

  task automatic cmd(input logic rd, input logic hiz, input logic [3:0] cnt,
                     input logic [7:0] d, input logic [7:0] pat, input bit poke);
    exp_t e;
    int n;
    n = (cnt > 8) ? 8 : int'(cnt);
    if (!rd) begin
      @(negedge clk_i); data_wr_i = 1'b1; data_wdata_i = d;
      @(negedge clk_i); data_wr_i = 1'b0;
      sb_data = d;
    end
    e.rd    = rd && n > 0;
    e.rises = n;
    e.busy  = 2 * HALF * n;
    e.cap   = (!rd && n > 0) ? (d >> (8 - n)) : 8'h00;
    if (n == 0)  e.data = sb_data;
    else if (rd) e.data = pat >> (8 - n);
    else         e.data = sb_data << n;
    e.oe = (n == 0) ? !hiz : (rd ? 1'b0 : !hiz);
    sb_data = e.data;
    sb_q.push_back(e);
    if (rd && n > 0) ee_sr = pat;
    @(negedge clk_i);
    cmd_wr_i = 1'b1; cmd_rd_i = rd; cmd_hiz_i = hiz; cmd_cnt_i = cnt;
    @(negedge clk_i);
    cmd_wr_i = 1'b0;
    if (rd && n > 0) ee_en = 1'b1;
    if (n == 0) begin
      chk("R5", "irq cycle after zero-count write", int'(irq_o), 1);
      chk("R5", "no busy on zero count", int'(busy_o), 0);
    end else begin
      chk("R1", "busy after start", int'(busy_o), 1);
    end
    if (poke) begin
      repeat (3) @(negedge clk_i);
      cmd_wr_i = 1'b1; cmd_rd_i = ~rd; cmd_hiz_i = ~hiz; cmd_cnt_i = 4'd8;
      data_wr_i = 1'b1; data_wdata_i = 8'hFF;
      @(negedge clk_i);
      cmd_wr_i = 1'b0; data_wr_i = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9", "busy reset", int'(busy_o), 0);
    chk("R9", "irq reset", int'(irq_o), 0);
    chk("R9", "sclk reset", int'(sclk_o), 0);
    chk("R9", "oe reset", int'(sdio_oe_o), 0);
    chk("R9", "data reset", int'(data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    cmd(1'b0, 1'b0, 4'd8,  8'hA5, 8'h00, 1'b0); // R3 full byte, stays driven
    cmd(1'b0, 1'b1, 4'd3,  8'hC3, 8'h00, 1'b0); // R6 release after write
    cmd(1'b1, 1'b0, 4'd0,  8'h00, 8'h00, 1'b0); // R5 take line, rd ignored
    cmd(1'b1, 1'b0, 4'd8,  8'h00, 8'h5A, 1'b0); // R4 full read
    cmd(1'b1, 1'b1, 4'd5,  8'h00, 8'hB7, 1'b0); // R4 right-justified partial
    ee_en = 1'b0;
    cmd(1'b0, 1'b0, 4'd0,  8'h3E, 8'h00, 1'b0); // R5 drive, data kept
    cmd(1'b0, 1'b1, 4'd0,  8'h3E, 8'h00, 1'b0); // R5 release
    cmd(1'b0, 1'b0, 4'd1,  8'h80, 8'h00, 1'b0); // R2 single pulse
    cmd(1'b0, 1'b0, 4'd15, 8'h3C, 8'h00, 1'b0); // R2 clamp to 8
    cmd(1'b0, 1'b0, 4'd4,  8'h96, 8'h00, 1'b1); // R8 writes during write
    cmd(1'b1, 1'b0, 4'd6,  8'h00, 8'hE4, 1'b1); // R8 writes during read
    ee_en = 1'b0;
    chk("R8", "no pending results", sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule